// File: doc/BRIEF.md
# Trigger-Mode Interrupt Request Latch

This block turns eight raw interrupt lines into a register of pending requests. Each line is either level-sensitive or edge-sensitive. A per-line trigger-mode register picks the mode, with 1 meaning level and 0 meaning edge. That register is written and read back through a byte-wide port. A fixed write mask, set per instance, forces some lines to stay in edge mode. With the default mask 8'hF8, bits 0 to 2 always read 0.

Every line is a small four-state machine. Its state holds two things: whether a request is pending, and the level of the input in the previous cycle. The four states are named as follows:
- `LN_QUIET`: input was low, nothing pending.
- `LN_HIGH_CLR`: input was high, nothing pending.
- `LN_LOW_PEND`: input was low, request pending.
- `LN_HIGH_PEND`: input was high, request pending.

A rising input moves a line into `LN_HIGH_PEND`. A low input moves a level line to `LN_QUIET`. On an edge line, a low input moves `LN_HIGH_PEND` to `LN_LOW_PEND`. An acknowledge moves an edge line to `LN_QUIET` or `LN_HIGH_CLR`. The initialisation pulse moves every line to `LN_LOW_PEND` if it is a level line with a request pending, and to `LN_QUIET` otherwise.

The ack and init arcs take priority over any input arc in the same cycle. Each rising input that is not suppressed produces a one-cycle report. The report says the request is new or merged into one already pending, and flags it as masked when that line's mask input is set. Priority resolution and vector generation are left to the logic that consumes `pending`.

Top module: `irq_trig_latch`

## Requirements
- R1: The asynchronous active-low reset clears the pending bits, the input history and the trigger-mode register to zero, and all report outputs read 0. A line that is already high when reset is released registers as a rising edge on the first clock.
- R2: For a level line, `pending` in the cycle after a rising clock edge equals the input sampled at that edge: high sets it and low clears it.
- R3: For an edge line, a pending bit is set only when the input is sampled high after having been sampled low. A falling input never clears it, and a steady high input does not set it again.
- R4: An acknowledge (`ack_valid` with line number `ack_idx`) clears that line's pending bit in the next cycle if the line is in edge mode. If the line is in level mode, the acknowledge has no effect.
- R5: When an edge line sees a rising input and an acknowledge in the same cycle, the acknowledge wins and the bit stays clear with no report. If the input is still high in the next cycle, the bit is set then and a single new report follows.
- R6: Each accepted rising input gives a one-cycle pulse, aligned with the `pending` update. `req_new` pulses if the bit was clear before. `req_merged` pulses if the bit was already set. The two never pulse together for the same line.
- R7: `req_masked[i]` pulses together with the report for line i only when `line_mask[i]` was set at the sampling edge. Without a rising input it stays 0.
- R8: A trigger-mode write stores `mode_wdata` ANDed with the instance write mask (8'hF8 by default, 8'hDE for a secondary instance). `mode_rdata` returns the stored value from the next cycle on.
- R9: The initialisation pulse clears every line's input history, and keeps pending bits only on lines in level mode.
- R10: In the cycle of the initialisation pulse, inputs and acknowledges are ignored. A line still high in the following cycle then registers as a fresh rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, inputs sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Raw interrupt lines |
| line_mask | input | 8 | Per-line mask used only for the masked report |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | 3 | Line number being acknowledged |
| init_pulse | input | 1 | Reset-from-initialisation pulse |
| mode_wr | input | 1 | Trigger-mode register write strobe |
| mode_wdata | input | 8 | Trigger-mode write data, 1 = level |
| mode_rdata | output | 8 | Trigger-mode register read-back |
| pending | output | 8 | Pending request bits |
| req_new | output | 8 | Pulse: rising input set a clear bit |
| req_merged | output | 8 | Pulse: rising input found the bit already set |
| req_masked | output | 8 | Pulse: the reported line was masked |

## Verification
Some properties are checked on every cycle by the assertions. Level lines track their input, and edge lines hold a pending bit unless acknowledged or initialised. Acknowledges clear edge lines but not level lines. The init pulse drops edge requests. New and merged reports are exclusive and always leave the bit set, a masked report never comes without an assertion report, and every mode write lands masked.

Other behaviour needs a known history and can only be shown by the bench scenarios. This covers the one-cycle-late re-set after an acknowledge wins a race, the history clearing done by reset and by initialisation, the new/merged distinction across a fall and a rise, and the differing write masks of the two instances.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

    // Per-line state: {previous level, pending}
    typedef enum logic [1:0] {
        LN_QUIET     = 2'b00,
        LN_LOW_PEND  = 2'b01,
        LN_HIGH_CLR  = 2'b10,
        LN_HIGH_PEND = 2'b11
    } line_state_e;

    typedef struct packed {
        logic is_new;
        logic is_merged;
        logic is_masked;
    } line_evt_t;

endpackage

// File: rtl/irq_trig_mode_reg.sv
module irq_trig_mode_reg #(
    parameter int                  WIDTH = 8,
    parameter logic [WIDTH-1:0]    WMASK = 'hF8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mode_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_en) begin
            mode_q <= wdata & WMASK;
        end
    end

    // R8
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mode_q == ($past(wdata) & WMASK)));

endmodule

// File: rtl/irq_trig_lane.sv
module irq_trig_lane
    import irq_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic level_mode,
    input  logic ack_hit,
    input  logic init_rst,
    input  logic mask_bit,
    output logic pend_o,
    output logic ev_new_o,
    output logic ev_merged_o,
    output logic ev_masked_o
);

    line_state_e state_q, state_d;
    line_evt_t   evt_d, evt_q;
    logic        hit_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // transition logic
    always_comb begin
        state_d = state_q;
        hit_d   = 1'b0;
        evt_d   = '0;
        if (init_rst) begin
            state_d = (level_mode && (state_q == LN_LOW_PEND || state_q == LN_HIGH_PEND))
                      ? LN_LOW_PEND : LN_QUIET;
        end else begin
            unique case (state_q)
                LN_QUIET: begin
                    if (line_in) begin
                        if (level_mode || !ack_hit) begin
                            state_d      = LN_HIGH_PEND;
                            evt_d.is_new = 1'b1;
                            hit_d        = 1'b1;
                        end
                    end
                end
                LN_HIGH_CLR: begin
                    if (!line_in) begin
                        state_d = LN_QUIET;
                    end else if (level_mode) begin
                        state_d = LN_HIGH_PEND;
                    end
                end
                LN_LOW_PEND: begin
                    if (line_in) begin
                        if (level_mode || !ack_hit) begin
                            state_d         = LN_HIGH_PEND;
                            evt_d.is_merged = 1'b1;
                            hit_d           = 1'b1;
                        end else begin
                            state_d = LN_QUIET;
                        end
                    end else if (level_mode || ack_hit) begin
                        state_d = LN_QUIET;
                    end
                end
                LN_HIGH_PEND: begin
                    if (line_in) begin
                        if (!level_mode && ack_hit) begin
                            state_d = LN_HIGH_CLR;
                        end
                    end else if (level_mode || ack_hit) begin
                        state_d = LN_QUIET;
                    end else begin
                        state_d = LN_LOW_PEND;
                    end
                end
            endcase
        end
        evt_d.is_masked = hit_d && mask_bit;
    end

    // registered report pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            LN_QUIET:     pend_o = 1'b0;
            LN_HIGH_CLR:  pend_o = 1'b0;
            LN_LOW_PEND:  pend_o = 1'b1;
            LN_HIGH_PEND: pend_o = 1'b1;
        endcase
        ev_new_o    = evt_q.is_new;
        ev_merged_o = evt_q.is_merged;
        ev_masked_o = evt_q.is_masked;
    end

    // R2
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mode && !init_rst) |=> (pend_o == $past(line_in)));

    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !level_mode && !ack_hit && !init_rst) |=> pend_o);

    // R4
    level_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && level_mode && line_in && !init_rst) |=> pend_o);

    // R4
    edge_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && !level_mode && !init_rst) |=> !pend_o);

    // R9
    init_drop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_rst && !level_mode) |=> !pend_o);

    // R6
    report_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_new_o || ev_merged_o) |-> pend_o);

    // R6
    report_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_new_o && ev_merged_o));

    // R7
    masked_needs_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_masked_o |-> (ev_new_o || ev_merged_o));

endmodule

// File: rtl/irq_trig_latch.sv
module irq_trig_latch #(
    parameter int                       NUM_LINES  = 8,
    parameter logic [NUM_LINES-1:0]     MODE_WMASK = 'hF8,
    localparam int                      IDX_W      = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] line_mask,
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_idx,
    input  logic                 init_pulse,
    input  logic                 mode_wr,
    input  logic [NUM_LINES-1:0] mode_wdata,
    output logic [NUM_LINES-1:0] mode_rdata,
    output logic [NUM_LINES-1:0] pending,
    output logic [NUM_LINES-1:0] req_new,
    output logic [NUM_LINES-1:0] req_merged,
    output logic [NUM_LINES-1:0] req_masked
);

    logic [NUM_LINES-1:0] mode_q;
    logic [NUM_LINES-1:0] ack_hit;

    irq_trig_mode_reg #(
        .WIDTH (NUM_LINES),
        .WMASK (MODE_WMASK)
    ) mode_reg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mode_wr),
        .wdata  (mode_wdata),
        .mode_q (mode_q)
    );

    assign mode_rdata = mode_q;

    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_lane
        assign ack_hit[gi] = ack_valid && (ack_idx == IDX_W'(gi));

        irq_trig_lane lane_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .line_in     (irq_in[gi]),
            .level_mode  (mode_q[gi]),
            .ack_hit     (ack_hit[gi]),
            .init_rst    (init_pulse),
            .mask_bit    (line_mask[gi]),
            .pend_o      (pending[gi]),
            .ev_new_o    (req_new[gi]),
            .ev_merged_o (req_merged[gi]),
            .ev_masked_o (req_masked[gi])
        );
    end

    // R4
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_hit));

    // R8
    forced_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rdata & ~MODE_WMASK) == '0);

endmodule

// File: tb/irq_trig_latch_tb_top.sv
`timescale 1ns/1ps
module irq_trig_latch_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic [7:0] line_mask = '0;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_idx = '0;
    logic       init_pulse = 1'b0;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic [7:0] mode_rdata, pending, req_new, req_merged, req_masked;
    logic [7:0] s_rdata, s_pend, s_new, s_merged, s_masked;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_trig_latch dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .line_mask(line_mask),
        .ack_valid(ack_valid), .ack_idx(ack_idx), .init_pulse(init_pulse),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .mode_rdata(mode_rdata),
        .pending(pending), .req_new(req_new), .req_merged(req_merged),
        .req_masked(req_masked)
    );

    irq_trig_latch #(.NUM_LINES(8), .MODE_WMASK(8'hDE)) dut_sec_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .line_mask(line_mask),
        .ack_valid(ack_valid), .ack_idx(ack_idx), .init_pulse(init_pulse),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .mode_rdata(s_rdata),
        .pending(s_pend), .req_new(s_new), .req_merged(s_merged),
        .req_masked(s_masked)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_in = '0; line_mask = '0; ack_valid = 1'b0;
        ack_idx = '0; init_pulse = 1'b0; mode_wr = 1'b0; mode_wdata = '0;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
    endtask

    task automatic write_mode(input logic [7:0] v);
        mode_wdata = v; mode_wr = 1'b1;
        cyc();
        mode_wr = 1'b0;
    endtask

    task automatic t_reset();
        irq_in = 8'h08;
        do_reset();
        chk("R1 pending after reset", pending, 8'h00);
        chk("R1 mode after reset", mode_rdata, 8'h00);
        chk("R1 merged after reset", req_merged, 8'h00);
        irq_in = 8'h08;
        cyc();
        chk("R1 history clear: new edge", req_new, 8'h08);
        chk("R1 history clear: pending", pending, 8'h08);
    endtask

    task automatic t_level();
        do_reset();
        write_mode(8'h10);
        irq_in = 8'h10; cyc();
        chk("R2 level high sets", pending, 8'h10);
        chk("R6 level new", req_new, 8'h10);
        cyc();
        chk("R6 pulse one cycle", req_new, 8'h00);
        irq_in = 8'h00; cyc();
        chk("R2 level low clears", pending, 8'h00);
        irq_in = 8'h10; cyc();
        ack_valid = 1'b1; ack_idx = 3'd4; cyc();
        ack_valid = 1'b0;
        chk("R4 ack on level ignored", pending, 8'h10);
    endtask

    task automatic t_edge();
        do_reset();
        irq_in = 8'h02; cyc();
        chk("R3 rising edge sets", pending, 8'h02);
        irq_in = 8'h00; cyc();
        chk("R3 falling keeps", pending, 8'h02);
        ack_valid = 1'b1; ack_idx = 3'd1; cyc();
        ack_valid = 1'b0;
        chk("R4 ack clears edge", pending, 8'h00);
        irq_in = 8'h02; cyc();
        ack_valid = 1'b1; cyc();
        ack_valid = 1'b0;
        chk("R4 ack while high", pending, 8'h00);
        cyc();
        chk("R3 steady high no re-set", pending, 8'h00);
        chk("R3 steady high no report", req_new, 8'h00);
    endtask

    task automatic t_merge();
        do_reset();
        irq_in = 8'h08; cyc();
        irq_in = 8'h00; cyc();
        irq_in = 8'h08; cyc();
        chk("R6 merged pulse", req_merged, 8'h08);
        chk("R6 no new on merge", req_new, 8'h00);
        chk("R6 pending after merge", pending, 8'h08);
    endtask

    task automatic t_masked();
        do_reset();
        line_mask = 8'h28;
        irq_in = 8'h08; cyc();
        chk("R7 masked with report", req_masked, 8'h08);
        chk("R7 report alongside", req_new, 8'h08);
        cyc();
        chk("R7 no rise no masked", req_masked, 8'h00);
    endtask

    task automatic t_race();
        do_reset();
        irq_in = 8'h04; ack_valid = 1'b1; ack_idx = 3'd2; cyc();
        ack_valid = 1'b0;
        chk("R5 ack wins pending", pending, 8'h00);
        chk("R5 ack wins no report", req_new, 8'h00);
        cyc();
        chk("R5 re-set next cycle", pending, 8'h04);
        chk("R5 single new report", req_new, 8'h04);
        cyc();
        chk("R5 no second report", req_new, 8'h00);
    endtask

    task automatic t_mode();
        do_reset();
        write_mode(8'hFF);
        chk("R8 primary write mask", mode_rdata, 8'hF8);
        chk("R8 secondary write mask", s_rdata, 8'hDE);
        write_mode(8'h10);
        chk("R8 read back", mode_rdata, 8'h10);
    endtask

    task automatic t_init();
        do_reset();
        write_mode(8'h30);
        irq_in = 8'h12; cyc();
        chk("R9 setup pending", pending, 8'h12);
        irq_in = 8'h1A; init_pulse = 1'b1; ack_valid = 1'b1; ack_idx = 3'd4; cyc();
        init_pulse = 1'b0; ack_valid = 1'b0;
        chk("R9 init keeps level only", pending, 8'h10);
        chk("R10 init ignores input", req_new, 8'h00);
        cyc();
        chk("R10 fresh edges after init", req_new, 8'h0A);
        chk("R9 level merge after init", req_merged, 8'h10);
        chk("R9 pending after init", pending, 8'h1A);
    endtask

    initial begin
        t_reset();
        t_level();
        t_edge();
        t_merge();
        t_masked();
        t_race();
        t_mode();
        t_init();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule